// File: doc/BRIEF.md
# Row-Layer Subiteration Sequencer

This controller paces a partially parallel quasi-cyclic LDPC decoder through its row layers. After a start pulse it captures the decoding configuration: number of block rows, number of block columns, iteration limit and code-rate index. It then repeats a fixed pattern of phase strobes for every row pass of every iteration. The node processors, message memories and routing network are outside the block and follow these strobes.

Each row pass covers two block rows at once, because two message groups are processed side by side. An iteration therefore takes one pass more than half the row count. A pass begins with two register-clear cycles and two memory-prefetch cycles. Each block column then takes a switch cycle followed by a process cycle, since the check and bit nodes share the routing network. Two write-back cycles close the pass. One cycle before each switch cycle, the sequencer reads the shift-table entry for the coming column. When the last iteration completes, it reports done.

Top module: `ldpc_subiter_seq`

## Requirements
- R1: After reset, busy, done, rom_rd and all five phase strobes are 0, and row_idx, col_idx and iter_idx are 0.
- R2: A start pulse in idle latches nrow, ncol, iter_limit and rate_sel. The next cycle begins a pass with clr_stb high for exactly 2 cycles, then pref_stb high for exactly 2 cycles.
- R3: After prefetch, each column c = 0, 1, ..., ncol-1 in ascending order gets one cycle with sw_stb, then one cycle with proc_stb, and col_idx equals c in both cycles.
- R4: The process cycle of the last column is followed by exactly 2 cycles of wb_stb, during which col_idx stays at ncol-1.
- R5: An iteration has 1 + floor(nrow/2) passes. row_idx is the pass number, from 0 upward, and resets to 0 at each new iteration. Every pass lasts 6 + 2·ncol cycles.
- R6: iter_limit iterations are run, and iter_idx counts from 0. busy stays high for exactly iter_limit·(1 + floor(nrow/2))·(6 + 2·ncol) cycles.
- R7: rom_rd is high on the second prefetch cycle and on every process cycle except the last column's. In those cycles rom_addr = {rate, row_idx, next column}, with the rate in the top RATE_W bits, the pass number in the next ROW_W bits and the column in the low COL_W bits. The next column is 0 on the prefetch cycle and col_idx+1 on a process cycle. Each such cycle is followed directly by a switch cycle.
- R8: done is high for exactly one cycle, the cycle after the final write-back, and busy is low in that cycle. After done, row_idx, col_idx and iter_idx are 0.
- R9: A start pulse or a change in the configuration inputs while busy has no effect on the strobe sequence, the indices or rom_addr.
- R10: At most one of clr_stb, pref_stb, sw_stb, proc_stb and wb_stb is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin decoding; ignored while busy |
| nrow | input | ROW_W | Block-row count (passes = 1 + nrow/2) |
| ncol | input | COL_W | Block-column count, at least 1 |
| iter_limit | input | ITER_W | Iterations to run, at least 1 |
| rate_sel | input | RATE_W | Code-rate index for the shift table |
| busy | output | 1 | Sequence in progress |
| clr_stb | output | 1 | Register-clear phase |
| pref_stb | output | 1 | Memory-prefetch phase |
| sw_stb | output | 1 | Switch (routing) cycle |
| proc_stb | output | 1 | Node-processing cycle |
| wb_stb | output | 1 | Write-back phase |
| rom_rd | output | 1 | Shift-table read enable |
| rom_addr | output | RATE_W+ROW_W+COL_W | Shift-table address |
| row_idx | output | ROW_W | Current pass number |
| col_idx | output | COL_W | Current block column |
| iter_idx | output | ITER_W | Current iteration |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that start arrives only with ncol and iter_limit nonzero, and that ncol fits the column field. Under that assumption the phase ordering is a fixed chain, and each assertion checks one link of it. The stimulus only starts runs with legal values, and it includes the smallest cases: one column, one pass and one iteration. While a run is busy, the bench drives garbage onto the configuration inputs and pulses start. This shows at the ports that latching makes those inputs irrelevant until idle.

// File: rtl/ldpc_subiter_seq.sv
module ldpc_subiter_seq #(
  parameter int ROW_W  = 4,
  parameter int COL_W  = 5,
  parameter int ITER_W = 5,
  parameter int RATE_W = 2,
  localparam int AW = RATE_W + ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ROW_W-1:0]  nrow,
  input  logic [COL_W-1:0]  ncol,
  input  logic [ITER_W-1:0] iter_limit,
  input  logic [RATE_W-1:0] rate_sel,
  output logic              busy,
  output logic              clr_stb,
  output logic              pref_stb,
  output logic              sw_stb,
  output logic              proc_stb,
  output logic              wb_stb,
  output logic              rom_rd,
  output logic [AW-1:0]     rom_addr,
  output logic [ROW_W-1:0]  row_idx,
  output logic [COL_W-1:0]  col_idx,
  output logic [ITER_W-1:0] iter_idx,
  output logic              done
);

  typedef enum logic [2:0] {S_IDLE, S_CLR, S_PRE, S_SW, S_PROC, S_WB} st_t;

  st_t               st;
  logic              sub;
  logic [ROW_W-1:0]  nrow_q, row_q;
  logic [COL_W-1:0]  ncol_q, col_q;
  logic [ITER_W-1:0] lim_q, iter_q;
  logic [RATE_W-1:0] rate_q;
  logic              done_q;

  wire last_col  = col_q == ncol_q - COL_W'(1);
  wire last_row  = row_q == (nrow_q >> 1);
  wire last_iter = iter_q == lim_q - ITER_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      sub    <= 1'b0;
      nrow_q <= '0;
      ncol_q <= '0;
      lim_q  <= '0;
      rate_q <= '0;
      row_q  <= '0;
      col_q  <= '0;
      iter_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          nrow_q <= nrow;
          ncol_q <= ncol;
          lim_q  <= iter_limit;
          rate_q <= rate_sel;
          row_q  <= '0;
          col_q  <= '0;
          iter_q <= '0;
          sub    <= 1'b0;
          st     <= S_CLR;
        end
        S_CLR: begin
          sub <= ~sub;
          if (sub) st <= S_PRE;
        end
        S_PRE: begin
          sub <= ~sub;
          if (sub) st <= S_SW;
        end
        S_SW: st <= S_PROC;
        S_PROC: begin
          if (last_col) begin
            sub <= 1'b0;
            st  <= S_WB;
          end else begin
            col_q <= col_q + COL_W'(1);
            st    <= S_SW;
          end
        end
        S_WB: begin
          sub <= ~sub;
          if (sub) begin
            col_q <= '0;
            if (!last_row) begin
              row_q <= row_q + ROW_W'(1);
              st    <= S_CLR;
            end else begin
              row_q <= '0;
              if (last_iter) begin
                iter_q <= '0;
                done_q <= 1'b1;
                st     <= S_IDLE;
              end else begin
                iter_q <= iter_q + ITER_W'(1);
                st     <= S_CLR;
              end
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy     = st != S_IDLE;
  assign clr_stb  = st == S_CLR;
  assign pref_stb = st == S_PRE;
  assign sw_stb   = st == S_SW;
  assign proc_stb = st == S_PROC;
  assign wb_stb   = st == S_WB;
  assign rom_rd   = (pref_stb && sub) || (proc_stb && !last_col);
  assign rom_addr = {rate_q, row_q, proc_stb ? col_q + COL_W'(1) : COL_W'(0)};
  assign row_idx  = row_q;
  assign col_idx  = col_q;
  assign iter_idx = iter_q;
  assign done     = done_q;

  a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({clr_stb, pref_stb, sw_stb, proc_stb, wb_stb}));

  a_r3_switch_then_proc: assert property (@(posedge clk) disable iff (!rst_n)
    sw_stb |=> proc_stb);

  a_r7_read_before_switch: assert property (@(posedge clk) disable iff (!rst_n)
    rom_rd |=> sw_stb);

  a_r2_clear_pair: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clr_stb) |=> clr_stb);

  a_r4_wb_pair: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wb_stb) |=> wb_stb);

  a_r8_done_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(wb_stb) && !busy));

  a_r9_rate_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(rom_addr[AW-1 -: RATE_W]));

endmodule

// File: tb/ldpc_subiter_seq_test.sv
module ldpc_subiter_seq_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] nrow = '0;
  logic [4:0] ncol = '0;
  logic [4:0] iter_limit = '0;
  logic [1:0] rate_sel = '0;
  logic busy, clr_stb, pref_stb, sw_stb, proc_stb, wb_stb, rom_rd, done;
  logic [10:0] rom_addr;
  logic [3:0] row_idx;
  logic [4:0] col_idx, iter_idx;

  always #4 clk = ~clk;

  ldpc_subiter_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .nrow(nrow), .ncol(ncol),
    .iter_limit(iter_limit), .rate_sel(rate_sel), .busy(busy),
    .clr_stb(clr_stb), .pref_stb(pref_stb), .sw_stb(sw_stb),
    .proc_stb(proc_stb), .wb_stb(wb_stb), .rom_rd(rom_rd),
    .rom_addr(rom_addr), .row_idx(row_idx), .col_idx(col_idx),
    .iter_idx(iter_idx), .done(done));

  typedef struct packed {
    logic [4:0] stb;
    logic rd, bsy, dn;
    logic [3:0] row;
    logic [4:0] col, it;
    logic [10:0] addr;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0, wdog = 0;

  always @(posedge clk) begin
    wdog <= wdog + 1;
    if (wdog > 100000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog expired: actual %0d cycles, expected < 100000", wdog);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  function automatic exp_t ent(input logic [4:0] s, input logic rd, input int r, input int c,
                               input int it, input int addr);
    exp_t e;
    e.stb = s; e.rd = rd; e.bsy = 1'b1; e.dn = 1'b0;
    e.row = 4'(r); e.col = 5'(c); e.it = 5'(it); e.addr = 11'(addr);
    return e;
  endfunction

  // strobe order: {clr, pre, sw, proc, wb}
  function automatic void build(input int nr, input int nc, input int lim, input int rate);
    int passes = 1 + nr / 2;
    exp_t e;
    for (int it = 0; it < lim; it++)
      for (int r = 0; r < passes; r++) begin
        q.push_back(ent(5'b10000, 0, r, 0, it, 0));
        q.push_back(ent(5'b10000, 0, r, 0, it, 0));
        q.push_back(ent(5'b01000, 0, r, 0, it, 0));
        q.push_back(ent(5'b01000, 1, r, 0, it, (rate << 9) | (r << 5)));
        for (int c = 0; c < nc; c++) begin
          q.push_back(ent(5'b00100, 0, r, c, it, 0));
          q.push_back(ent(5'b00010, c < nc - 1, r, c, it, (rate << 9) | (r << 5) | (c + 1)));
        end
        q.push_back(ent(5'b00001, 0, r, nc - 1, it, 0));
        q.push_back(ent(5'b00001, 0, r, nc - 1, it, 0));
      end
    e = '0; e.dn = 1'b1;
    q.push_back(e);
    e = '0;
    q.push_back(e);
  endfunction

  task automatic compare(input exp_t e);
    logic [4:0] s = {clr_stb, pref_stb, sw_stb, proc_stb, wb_stb};
    chk(s == e.stb, "R2/R3/R4 phase strobes", s, e.stb);
    chk(row_idx == e.row && iter_idx == e.it, "R5/R6 row and iteration index",
        {iter_idx, row_idx}, {e.it, e.row});
    chk(col_idx == e.col, "R3 column index", col_idx, e.col);
    chk(rom_rd == e.rd && (!e.rd || rom_addr == e.addr), "R7 shift-table read",
        {rom_rd, rom_addr}, {e.rd, e.addr});
    chk(busy == e.bsy && done == e.dn, "R8 busy/done", {busy, done}, {e.bsy, e.dn});
    chk($countones(s) <= 1, "R10 single strobe", $countones(s), 1);
  endtask

  task automatic run(input int nr, input int nc, input int lim, input int rate, input int poke);
    int busycnt = 0;
    int idx = 0;
    int expect_busy = lim * (1 + nr / 2) * (6 + 2 * nc);
    build(nr, nc, lim, rate);
    @(negedge clk);
    nrow = 4'(nr); ncol = 5'(nc); iter_limit = 5'(lim); rate_sel = 2'(rate);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    nrow = 4'hF; ncol = 5'd3; iter_limit = 5'd9; rate_sel = 2'(~rate);
    while (q.size() > 0) begin
      exp_t e = q.pop_front();
      compare(e);
      if (busy) busycnt++;
      start = (idx == poke); // R9: start while busy must be ignored
      idx++;
      @(negedge clk);
    end
    start = 1'b0;
    chk(busycnt == expect_busy, "R6 busy cycle count", busycnt, expect_busy);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !rom_rd && {clr_stb, pref_stb, sw_stb, proc_stb, wb_stb} == 5'b0,
        "R1 reset outputs", {busy, done, rom_rd}, 0);
    chk(row_idx == 0 && col_idx == 0 && iter_idx == 0, "R1 reset indices",
        {row_idx, col_idx, iter_idx}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy, "R1 idle without start", busy, 0);
    run(3, 4, 2, 1, -1);
    run(0, 1, 1, 2, -1);
    run(7, 24, 2, 3, 5);
    run(12, 5, 3, 0, 40);
    run(1, 2, 1, 1, 3);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule